// File: doc/BRIEF.md
# Packed-Slot Stack Processor Core

A compact stack-machine processor with a 20-bit memory word and a 21-bit internal datapath. Each word that the core fetches holds four 5-bit instructions. The core keeps the word in an instruction register and executes the four slots in order before it fetches again.

Operands are implicit. One operand is always the top-of-stack register T, and the other is always the entry just below it in the data stack. The ALU computes every candidate result at all times, and an instruction only chooses which one is loaded into T. Bit 20 of T is the carry out of addition, and a conditional branch can test it. A separate return stack holds subroutine return addresses. An address register serves loads and stores, including forms that increment it after the access.

All memory traffic goes through one request/acknowledge port. The port carries instruction fetches, in-line literals and data accesses. Memory may take any number of cycles to respond.

Top module: `stk20_core`

## Requirements
- R1: Reset starts a read request at word 0. Slot 0 sits in bits 19:15, slot 1 in 14:10, slot 2 in 9:5 and slot 3 in 4:0. The slots run in that order. After slot 3 the next word is fetched from PC, and each fetch advances PC by one.
- R2: Opcodes are JUMP=0, CALL=1, RET=2, JZ=3, JCZ=4, LOAD=8, STORE=9, LOADP=10, STOREP=11, LIT=12, COM=16, XOR=17, AND=18, ADD=19, SHL=20, SHR=21, ADDNZ=22, LOADA=24, STOREA=25, DUP=26, DROP=27, OVER=28 and NOP=29.
- R3: XOR, AND and ADD combine T with the data-stack top S, put the result in T and pop S. ADD adds the low 20 bits of T and S and puts the carry out in T bit 20.
- R4: COM inverts all 21 bits of T. SHL gives {T[19:0],0}. SHR gives {0,T[20:1]}. ADDNZ sets T to the ADD sum only when T bit 0 is 1, and neither pops nor otherwise changes T.
- R5: DUP pushes T. DROP moves S into T and pops. OVER pushes T and then loads the former S into T.
- R6: A jump-type instruction in slot k takes the (15-5k) bits below that slot as the low target bits. The higher bits come from PC. Execution resumes at slot 0 of the target word.
- R7: JZ is taken when T[19:0] is zero. JCZ is taken when T bit 20 is clear. Neither changes T. When not taken, both skip the rest of the word and fetch the next one.
- R8: CALL pushes PC, which is the address of the word after the call, onto the return stack and then jumps. RET pops the return stack into PC.
- R9: LOAD pushes T and loads memory at address A, zero-extended, into T. STORE writes T[19:0] to address A and pops. LOADP and STOREP do the same and then add one to A.
- R10: LIT pushes T, loads the word at PC into T and advances PC. Later slots of the same word still execute.
- R11: LOADA pushes T and loads A into T. STOREA copies T[19:0] into A and pops.
- R12: Both stacks are 8-entry circular files with no overflow check. A ninth push without a pop overwrites the oldest entry.
- R13: While a request waits for acknowledge, the core holds the request, address, write enable and write data steady.
- R14: Opcodes outside the R2 table act as NOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 20 | Word address |
| mem_wdata | output | 20 | Write data |
| mem_rdata | input | 20 | Read data, valid with acknowledge |
| mem_ack | input | 1 | Access completes at this clock edge |

## Verification
Two things can meet in one instruction. A stack push can land in the same cycle as a memory completion: LIT, LOAD and LOADP push T while the acknowledged read word enters T. STORE and STOREP pop in the same cycle the write completes. These cases are provoked by packing them next to ALU and stack operations, both in directed programs and in seeded random programs, while the memory model inserts a random acknowledge delay. The bench judges the result by running a bench-side instruction model over the same program image and comparing a memory dump of T and both the data-stack contents and the stored data words.

// File: rtl/stk20_pkg.sv
package stk20_pkg;
    localparam int WORD_W = 20;
    localparam int SLOT_W = 5;
    localparam int SLOTS  = WORD_W / SLOT_W;
    localparam int DATA_W = WORD_W + 1;
    localparam int SLOT_IW = $clog2(SLOTS);

    typedef enum logic [4:0] {
        OP_JUMP = 5'd0,  OP_CALL = 5'd1,  OP_RET = 5'd2,   OP_JZ = 5'd3,
        OP_JCZ = 5'd4,   OP_LOAD = 5'd8,  OP_STORE = 5'd9, OP_LOADP = 5'd10,
        OP_STOREP = 5'd11, OP_LIT = 5'd12, OP_COM = 5'd16, OP_XOR = 5'd17,
        OP_AND = 5'd18,  OP_ADD = 5'd19,  OP_SHL = 5'd20,  OP_SHR = 5'd21,
        OP_ADDNZ = 5'd22, OP_LOADA = 5'd24, OP_STOREA = 5'd25, OP_DUP = 5'd26,
        OP_DROP = 5'd27, OP_OVER = 5'd28, OP_NOP = 5'd29
    } opcode_e;

    typedef enum logic [1:0] {PH_FETCH, PH_EXEC, PH_DATA} phase_e;

    typedef struct packed {
        logic [DATA_W-1:0] com;
        logic [DATA_W-1:0] shl;
        logic [DATA_W-1:0] shr;
        logic [DATA_W-1:0] xr;
        logic [DATA_W-1:0] nd;
        logic [DATA_W-1:0] add;
        logic [DATA_W-1:0] addnz;
    } alu_res_t;

    typedef struct packed {
        phase_e             ph;
        logic [SLOT_IW-1:0] slot;
        logic [WORD_W-1:0]  ir;
        logic [WORD_W-1:0]  pc;
        logic [WORD_W-1:0]  a;
        logic [DATA_W-1:0]  t;
    } core_t;
endpackage

// File: rtl/stk20_alu.sv
module stk20_alu
    import stk20_pkg::*;
(
    input  logic [DATA_W-1:0] t_i,
    input  logic [DATA_W-1:0] s_i,
    output alu_res_t          res_o
);
    logic [DATA_W-1:0] sum;
    assign sum = {1'b0, t_i[WORD_W-1:0]} + {1'b0, s_i[WORD_W-1:0]};

    // every result is formed continuously; the core picks one
    always_comb begin
        res_o.com   = ~t_i;
        res_o.shl   = {t_i[WORD_W-1:0], 1'b0};
        res_o.shr   = {1'b0, t_i[DATA_W-1:1]};
        res_o.xr    = t_i ^ s_i;
        res_o.nd    = t_i & s_i;
        res_o.add   = sum;
        res_o.addnz = t_i[0] ? sum : t_i;
    end
endmodule

// File: rtl/stk20_stack.sv
module stk20_stack #(
    parameter int W     = 21,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] top
);
    localparam int PW = $clog2(DEPTH);

    logic [PW-1:0] sp_d, sp_q;
    logic [W-1:0]  cell_q [DEPTH];

    always_comb begin
        sp_d = sp_q;
        if (push && !pop)      sp_d = sp_q + PW'(1);
        else if (pop && !push) sp_d = sp_q - PW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= '0;
            for (int i = 0; i < DEPTH; i++) cell_q[i] <= '0;
        end else begin
            sp_q <= sp_d;
            if (push) cell_q[sp_d] <= din;
        end
    end

    assign top = cell_q[sp_q];

    // R12: a pushed value is visible on top the next cycle, even on wrap
    a_r12_push_top: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> (top == $past(din)));
endmodule

// File: rtl/stk20_core.sv
module stk20_core
    import stk20_pkg::*;
#(
    parameter int DS_DEPTH = 8,
    parameter int RS_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    localparam int TOP_SH = WORD_W - SLOT_W;

    core_t core_d, core_q;

    logic              ds_push, ds_pop, rs_push, rs_pop;
    logic [DATA_W-1:0] ds_din, ds_top;
    logic [WORD_W-1:0] rs_din, rs_top;
    alu_res_t          alu;

    int                sh;
    logic [WORD_W-1:0] shifted, mask, target;
    opcode_e           cur_op;
    logic              last_slot;

    stk20_alu u_alu (.t_i(core_q.t), .s_i(ds_top), .res_o(alu));

    stk20_stack #(.W(DATA_W), .DEPTH(DS_DEPTH)) u_dstk (
        .clk(clk), .rst_n(rst_n), .push(ds_push), .pop(ds_pop),
        .din(ds_din), .top(ds_top));

    stk20_stack #(.W(WORD_W), .DEPTH(RS_DEPTH)) u_rstk (
        .clk(clk), .rst_n(rst_n), .push(rs_push), .pop(rs_pop),
        .din(rs_din), .top(rs_top));

    // slot decode: bits below the slot double as the jump target
    always_comb begin
        sh        = TOP_SH - SLOT_W * int'(core_q.slot);
        shifted   = core_q.ir >> sh;
        cur_op    = opcode_e'(shifted[SLOT_W-1:0]);
        mask      = ~({WORD_W{1'b1}} << sh);
        target    = (core_q.pc & ~mask) | (core_q.ir & mask);
        last_slot = (int'(core_q.slot) == SLOTS - 1);
    end

    always_comb begin
        logic adv;
        core_d    = core_q;
        adv       = 1'b0;
        ds_push   = 1'b0;
        ds_pop    = 1'b0;
        ds_din    = core_q.t;
        rs_push   = 1'b0;
        rs_pop    = 1'b0;
        rs_din    = core_q.pc;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = core_q.pc;
        mem_wdata = core_q.t[WORD_W-1:0];

        unique case (core_q.ph)
            PH_FETCH: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    core_d.ir   = mem_rdata;
                    core_d.pc   = core_q.pc + WORD_W'(1);
                    core_d.slot = '0;
                    core_d.ph   = PH_EXEC;
                end
            end
            PH_EXEC: begin
                case (cur_op)
                    OP_JUMP: begin core_d.pc = target; core_d.ph = PH_FETCH; end
                    OP_CALL: begin
                        rs_push = 1'b1;
                        core_d.pc = target;
                        core_d.ph = PH_FETCH;
                    end
                    OP_RET: begin
                        rs_pop = 1'b1;
                        core_d.pc = rs_top;
                        core_d.ph = PH_FETCH;
                    end
                    OP_JZ, OP_JCZ: begin
                        if ((cur_op == OP_JZ) ? (core_q.t[WORD_W-1:0] == '0)
                                              : !core_q.t[WORD_W])
                            core_d.pc = target;
                        core_d.ph = PH_FETCH;
                    end
                    OP_LOAD, OP_STORE, OP_LOADP, OP_STOREP, OP_LIT:
                        core_d.ph = PH_DATA;
                    OP_COM:   begin core_d.t = alu.com;   adv = 1'b1; end
                    OP_SHL:   begin core_d.t = alu.shl;   adv = 1'b1; end
                    OP_SHR:   begin core_d.t = alu.shr;   adv = 1'b1; end
                    OP_ADDNZ: begin core_d.t = alu.addnz; adv = 1'b1; end
                    OP_XOR: begin core_d.t = alu.xr;  ds_pop = 1'b1; adv = 1'b1; end
                    OP_AND: begin core_d.t = alu.nd;  ds_pop = 1'b1; adv = 1'b1; end
                    OP_ADD: begin core_d.t = alu.add; ds_pop = 1'b1; adv = 1'b1; end
                    OP_LOADA: begin
                        ds_push = 1'b1;
                        core_d.t = {1'b0, core_q.a};
                        adv = 1'b1;
                    end
                    OP_STOREA: begin
                        core_d.a = core_q.t[WORD_W-1:0];
                        core_d.t = ds_top;
                        ds_pop = 1'b1;
                        adv = 1'b1;
                    end
                    OP_DUP:  begin ds_push = 1'b1; adv = 1'b1; end
                    OP_DROP: begin core_d.t = ds_top; ds_pop = 1'b1; adv = 1'b1; end
                    OP_OVER: begin core_d.t = ds_top; ds_push = 1'b1; adv = 1'b1; end
                    default: adv = 1'b1;
                endcase
            end
            PH_DATA: begin
                mem_req  = 1'b1;
                mem_we   = (cur_op == OP_STORE) || (cur_op == OP_STOREP);
                mem_addr = (cur_op == OP_LIT) ? core_q.pc : core_q.a;
                if (mem_ack) begin
                    adv = 1'b1;
                    if (mem_we) begin
                        core_d.t = ds_top;
                        ds_pop   = 1'b1;
                    end else begin
                        core_d.t = {1'b0, mem_rdata};
                        ds_push  = 1'b1;
                    end
                    if (cur_op == OP_LOADP || cur_op == OP_STOREP)
                        core_d.a = core_q.a + WORD_W'(1);
                    if (cur_op == OP_LIT)
                        core_d.pc = core_q.pc + WORD_W'(1);
                end
            end
            default: core_d.ph = PH_FETCH;
        endcase

        if (adv) begin
            if (last_slot) core_d.ph = PH_FETCH;
            else begin
                core_d.ph   = PH_EXEC;
                core_d.slot = core_q.slot + SLOT_IW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_q    <= '0;
            core_q.ph <= PH_FETCH;
        end else begin
            core_q <= core_d;
        end
    end

    // R13: a pending request is held unchanged until acknowledged
    a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));

    // R1: a completed fetch starts at slot 0 and advances PC by one
    a_r1_fetch_start: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.ph == PH_FETCH && mem_ack) |=>
            (core_q.ph == PH_EXEC && core_q.slot == '0 &&
             core_q.pc == $past(core_q.pc) + WORD_W'(1)));

    // R8: return lands on the address held by the return stack
    a_r8_ret_target: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.ph == PH_EXEC && cur_op == OP_RET) |=>
            (core_q.pc == $past(rs_top) && core_q.ph == PH_FETCH));

    // R7: conditional branches never alter T
    a_r7_branch_keeps_t: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.ph == PH_EXEC && (cur_op == OP_JZ || cur_op == OP_JCZ)) |=>
            $stable(core_q.t));

    // R9: post-increment forms step A by one on completion
    a_r9_postinc: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.ph == PH_DATA && mem_ack &&
         (cur_op == OP_LOADP || cur_op == OP_STOREP)) |=>
            (core_q.a == $past(core_q.a) + WORD_W'(1)));
endmodule

// File: tb/stk20_core_test.sv
module stk20_core_test;
    localparam int JUMP=0, CALL=1, RET=2, JZ=3, JCZ=4, LOAD=8, STORE=9,
                   LOADP=10, STOREP=11, LIT=12, COM=16, XOR=17, AND=18,
                   ADD=19, SHL=20, SHR=21, ADDNZ=22, LOADA=24, STOREA=25,
                   DUP=26, DROP=27, OVER=28, NOP=29;
    localparam int DUMP = 'hC0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_req, mem_we, mem_ack;
    logic [19:0] mem_addr, mem_wdata, mem_rdata;

    logic [19:0] dmem [256];
    logic [19:0] rmem [256];
    logic [19:0] pm   [256];
    int          wp;
    int          checks = 0, errors = 0;
    logic        do_load = 1'b0;
    logic        halted;
    int          hs_bad, lat, halt_at;
    logic        prev_wait, p_we;
    logic [19:0] p_addr, p_wd;

    always #5 clk = ~clk;

    stk20_core uut (.clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
                    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
                    .mem_rdata(mem_rdata), .mem_ack(mem_ack));

    assign mem_rdata = dmem[mem_addr[7:0]];

    // memory model acts on the falling edge, away from the core's edge
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0; halted <= 1'b0; hs_bad <= 0; lat <= 0; prev_wait <= 1'b0;
            if (do_load) for (int i = 0; i < 256; i++) dmem[i] <= pm[i];
        end else begin
            if (prev_wait && (!mem_req || mem_addr != p_addr || mem_we != p_we ||
                              (mem_we && mem_wdata != p_wd)))
                hs_bad <= hs_bad + 1;
            if (mem_ack) begin
                mem_ack <= 1'b0; prev_wait <= 1'b0;
            end else if (mem_req) begin
                if (lat == 0) begin
                    mem_ack <= 1'b1; prev_wait <= 1'b0;
                    lat <= int'($urandom % 3);
                    if (mem_we) dmem[mem_addr[7:0]] <= mem_wdata;
                    else if (int'(mem_addr) == halt_at) halted <= 1'b1;
                end else begin
                    lat <= lat - 1; prev_wait <= 1'b1;
                    p_addr <= mem_addr; p_we <= mem_we; p_wd <= mem_wdata;
                end
            end else prev_wait <= 1'b0;
        end
    end

    function automatic logic [19:0] w4(int a, int b, int c, int d);
        return {a[4:0], b[4:0], c[4:0], d[4:0]};
    endfunction

    function automatic logic [19:0] jmp(int slot, int op, int tgt, int p0, int p1, int p2);
        int sh = 15 - 5 * slot;
        logic [19:0] w = w4(p0, p1, p2, NOP);
        logic [19:0] m = 20'((64'd1 << sh) - 1);
        logic [19:0] hi = ~20'((64'd1 << (sh + 5)) - 1);
        return (w & hi) | (20'(op) << sh) | (20'(tgt) & m);
    endfunction

    task automatic put(logic [19:0] v);
        pm[wp] = v; wp++;
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 256; i++) pm[i] = '0;
        wp = 0;
    endtask

    // dump T and the data stack to DUMP.., then park; returns halt address
    task automatic finish_prog();
        put(w4(LIT, STOREA, STOREP, STOREP));
        put(20'(DUMP));
        put(w4(STOREP, STOREP, STOREP, STOREP));
        put(w4(STOREP, STOREP, STOREP, NOP));
        halt_at = wp;
        put(jmp(0, JUMP, wp, 0, 0, 0));
    endtask

    // bench-side instruction model built from the requirements
    task automatic ref_run();
        logic [20:0] t = '0, s, sum;
        logic [19:0] pc = '0, a = '0, ir, m, tgt;
        logic [20:0] ds [8];
        logic [19:0] rs [8];
        int dsp = 0, rsp = 0, steps = 0, op, sh;
        bit leave;
        for (int i = 0; i < 8; i++) begin ds[i] = '0; rs[i] = '0; end
        while (int'(pc) != halt_at && steps < 20000) begin
            steps++;
            ir = rmem[pc[7:0]];
            pc = pc + 20'd1;
            leave = 0;
            for (int sl = 0; sl < 4 && !leave; sl++) begin
                sh = 15 - 5 * sl;
                op = int'((ir >> sh) & 20'h1F);
                m = 20'((64'd1 << sh) - 1);
                tgt = (pc & ~m) | (ir & m);
                s = ds[dsp];
                sum = {1'b0, t[19:0]} + {1'b0, s[19:0]};
                case (op)
                    JUMP: begin pc = tgt; leave = 1; end
                    CALL: begin rsp = (rsp + 1) % 8; rs[rsp] = pc; pc = tgt; leave = 1; end
                    RET:  begin pc = rs[rsp]; rsp = (rsp + 7) % 8; leave = 1; end
                    JZ:   begin if (t[19:0] == 0) pc = tgt; leave = 1; end
                    JCZ:  begin if (!t[20]) pc = tgt; leave = 1; end
                    LOAD, LOADP: begin
                        dsp = (dsp + 1) % 8; ds[dsp] = t; t = {1'b0, rmem[a[7:0]]};
                        if (op == LOADP) a = a + 1;
                    end
                    STORE, STOREP: begin
                        rmem[a[7:0]] = t[19:0]; t = s; dsp = (dsp + 7) % 8;
                        if (op == STOREP) a = a + 1;
                    end
                    LIT: begin
                        dsp = (dsp + 1) % 8; ds[dsp] = t; t = {1'b0, rmem[pc[7:0]]}; pc = pc + 1;
                    end
                    COM: t = ~t;
                    SHL: t = {t[19:0], 1'b0};
                    SHR: t = {1'b0, t[20:1]};
                    ADDNZ: if (t[0]) t = sum;
                    XOR: begin t = t ^ s; dsp = (dsp + 7) % 8; end
                    AND: begin t = t & s; dsp = (dsp + 7) % 8; end
                    ADD: begin t = sum; dsp = (dsp + 7) % 8; end
                    LOADA: begin dsp = (dsp + 1) % 8; ds[dsp] = t; t = {1'b0, a}; end
                    STOREA: begin a = t[19:0]; t = s; dsp = (dsp + 7) % 8; end
                    DUP: begin dsp = (dsp + 1) % 8; ds[dsp] = t; end
                    DROP: begin t = s; dsp = (dsp + 7) % 8; end
                    OVER: begin dsp = (dsp + 1) % 8; ds[dsp] = t; t = s; end
                    default: ;
                endcase
            end
        end
    endtask

    task automatic run_prog(string tag);
        rst_n = 1'b0; do_load = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); do_load = 1'b0;
        for (int i = 0; i < 256; i++) rmem[i] = pm[i];
        ref_run();
        rst_n = 1'b1;
        for (int i = 0; i < 20000 && !halted; i++) @(posedge clk);
        @(negedge clk);
        checks++;
        if (!halted) begin
            errors++;
            $display("FAIL %s watchdog: halted=%0b expected 1", tag, halted);
        end
        for (int i = DUMP; i < DUMP + 32; i++) begin
            checks++;
            if (dmem[i] !== rmem[i]) begin
                errors++;
                $display("FAIL %s word %h: got %h exp %h", tag, i, dmem[i], rmem[i]);
            end
        end
        checks++;
        if (hs_bad != 0) begin
            errors++;
            $display("FAIL R13 %s handshake: got %0d changes exp 0", tag, hs_bad);
        end
    endtask

    initial begin
        int ops [14] = '{COM, XOR, AND, ADD, SHL, SHR, ADDNZ, LOADA, DUP, DROP,
                         OVER, NOP, LIT, 7};
        void'($urandom(32'd1234));
        halt_at = 255;
        clear_prog();
        // R1: reset state requests a read of word 0
        repeat (2) @(posedge clk);
        @(negedge clk);
        checks++;
        if (!(mem_req === 1'b1 && mem_we === 1'b0 && mem_addr === 20'd0)) begin
            errors++;
            $display("FAIL R1 reset: got req=%b we=%b addr=%h exp 1 0 00000",
                     mem_req, mem_we, mem_addr);
        end

        // R3 R4 R2: ALU selection and carry
        clear_prog();
        put(w4(LIT, LIT, ADD, DUP)); put(20'hFFFFF); put(20'h00003);
        put(w4(COM, OVER, XOR, DUP)); put(w4(SHL, DUP, SHR, NOP));
        put(w4(LIT, AND, LIT, ADDNZ)); put(20'h0F0F1); put(20'h12345);
        put(w4(DUP, ADDNZ, SHL, ADDNZ));
        finish_prog(); run_prog("R3 R4 alu");

        // R6 R7: branches taken and not taken
        clear_prog();
        put(jmp(1, JZ, 3, LIT, 0, 0)); put(20'd0); put(w4(LIT, DUP, DUP, DUP));
        put(w4(LIT, LIT, ADD, DUP)); put(20'hFFFFF); put(20'd1);
        put(jmp(1, JZ, 9, DUP, 0, 0)); put(w4(LIT, DUP, NOP, NOP)); put(20'h22222);
        put(jmp(1, JCZ, 12, DUP, 0, 0)); put(w4(COM, NOP, NOP, NOP));
        put(jmp(1, JZ, 14, DUP, 0, 0)); put(jmp(1, JCZ, 15, DUP, 0, 0));
        put(w4(LIT, DUP, NOP, NOP)); put(20'h33333);
        put(jmp(2, JUMP, 17, DUP, DUP, 0)); put(w4(LIT, NOP, NOP, NOP));
        finish_prog(); run_prog("R6 R7 branch");

        // R8: nested call and return
        clear_prog();
        put(jmp(1, CALL, 6, LIT, 0, 0)); put(20'h00005);
        put(w4(LIT, ADD, NOP, NOP)); put(20'h00100);
        put(jmp(0, JUMP, 9, 0, 0, 0)); put(w4(LIT, NOP, NOP, NOP));
        put(jmp(1, CALL, 8, DUP, 0, 0)); put(w4(SHL, RET, NOP, NOP));
        put(w4(DUP, ADD, RET, NOP));
        finish_prog(); run_prog("R8 call");

        // R9 R10 R11: memory forms, literals, address register
        clear_prog();
        put(w4(LIT, STOREA, LIT, STOREP)); put(20'h000D0); put(20'h0ABCD);
        put(w4(LIT, STOREP, LOADA, LIT)); put(20'h01234); put(20'h000D8);
        put(w4(STOREA, LIT, STORE, LOADA)); put(20'h55555);
        put(w4(LIT, STOREA, LOADP, LOADP)); put(20'h000D0);
        put(w4(LOAD, LOADA, NOP, NOP));
        finish_prog(); run_prog("R9 R10 R11 mem");

        // R12 R5: stack wrap past eight entries
        clear_prog();
        put(w4(LIT, DUP, OVER, DUP)); put(20'h00011);
        put(w4(LIT, LIT, LIT, LIT));
        for (int i = 0; i < 4; i++) put(20'(32'h100 + i));
        put(w4(LIT, LIT, LIT, LIT));
        for (int i = 0; i < 4; i++) put(20'(32'h200 + i));
        put(w4(DROP, DROP, DROP, OVER)); put(w4(DROP, DROP, DUP, DROP));
        finish_prog(); run_prog("R12 R5 wrap");

        // R14: unassigned codes leave state alone
        clear_prog();
        put(w4(LIT, 5, 6, 7)); put(20'h4A5A5);
        put(w4(13, 14, 15, 23)); put(w4(30, 31, NOP, DUP));
        finish_prog(); run_prog("R14 unassigned");

        // R1 R3 R4 R5 R10 R14: random slot mixes with literals
        for (int p = 0; p < 12; p++) begin
            int nw, nlit;
            int op [4];
            clear_prog();
            nw = 4 + int'($urandom % 6);
            for (int w = 0; w < nw; w++) begin
                nlit = 0;
                for (int k = 0; k < 4; k++) begin
                    op[k] = ops[$urandom % 14];
                    if (op[k] == LIT) nlit++;
                end
                put(w4(op[0], op[1], op[2], op[3]));
                for (int k = 0; k < nlit; k++) put(20'($urandom));
            end
            finish_prog(); run_prog("R1 R3 R4 R5 R10 R14 random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule